// File: doc/BRIEF.md
# Receive FIFO Watermark DMA Requester

This block decides when a DMA engine should empty a shared receive FIFO of 32-bit words into host memory. It compares the FIFO fill level, sampled every clock, against a watermark built from a programmable threshold field and two scaling enables. Once the level climbs strictly above the watermark, the block enters a draining state. It keeps requesting transfers until the FIFO reports zero words, so each burst empties the FIFO instead of stopping back at the watermark.

A request is only presented while the target channel has a host buffer to write into. A mode input chooses how buffer availability is judged. In one mode, a hold flag taken from the current descriptor stops the transfer. In the other mode, the transfer stops when the current receive descriptor address has caught up with the last descriptor address. A blocked request is withdrawn at once, but the draining state is kept, so the transfer resumes as soon as the block clears. A configuration warning reports watermark settings that cannot be used, and such settings suppress requests.

Top module: `rx_watermark_dma`

## Requirements
- R1: The watermark equals `thrField` times a scale factor. The factor is 1 when `mulX2En`=0 and `mulX4En`=0, 2 when only `mulX2En`=1, 4 when only `mulX4En`=1, and 8 when both are 1.
- R2: When `fifoLevel` is strictly greater than the watermark at a rising clock edge, the block enters draining, and `dmaReq` is high in the following cycle if nothing blocks it. A level equal to the watermark does not start draining.
- R3: While draining, `dmaReq` stays high even after `fifoLevel` falls to or below the watermark, as long as the level is non-zero and nothing blocks the request.
- R4: `dmaReq` is low in any cycle where `fifoLevel` is 0. Draining ends at a clock edge where the level is 0, and the request does not return until the level is again above the watermark at an edge.
- R5: With `modeSel`=0, `dmaReq` is low in every cycle where `holdSeen`=1. In this mode the descriptor addresses have no effect.
- R6: With `modeSel`=1, `dmaReq` is low in every cycle where `curDescAddr` equals `lastDescAddr`. In this mode `holdSeen` has no effect.
- R7: When a blocking condition clears during draining, `dmaReq` returns in the same cycle. The level does not need to cross the watermark again.
- R8: `cfgWarn` is high exactly when both scale enables are 1 or when the watermark is 128 words or more.
- R9: While the watermark is 128 or more, `dmaReq` is low, and draining cannot start.
- R10: `fifoPop` is high exactly in cycles where `dmaReq` and `dmaAck` are both high, one word per such cycle.
- R11: While `rstN`=0 at a clock edge, the draining state is cleared, so `dmaReq` is low in the following cycle whatever the FIFO level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| thrField | input | THR_W (7) | Threshold in words before scaling |
| mulX2En | input | 1 | Scale-by-2 enable |
| mulX4En | input | 1 | Scale-by-4 enable |
| modeSel | input | 1 | Buffer test: 0 = hold flag, 1 = address compare |
| holdSeen | input | 1 | Hold flag of the current descriptor |
| curDescAddr | input | ADDR_W (32) | Current receive descriptor address |
| lastDescAddr | input | ADDR_W (32) | Last descriptor address |
| fifoLevel | input | LVL_W (8) | Words held in the FIFO, 0 to 128 |
| dmaAck | input | 1 | DMA engine accepts a word this cycle |
| dmaReq | output | 1 | Transfer request, a level signal |
| fifoPop | output | 1 | Remove one word from the FIFO |
| cfgWarn | output | 1 | Watermark configuration warning |

## Verification
The only internal state is the draining flag. If that flag were wrong, it would show at `dmaReq` within one clock. A flag that failed to clear would keep requesting on a small level below the watermark after the FIFO had emptied. A flag that failed to set, or cleared early, would drop the request partway through a drain, while the level is still at or below the watermark. A wrong watermark scale shows as a request starting one level early or late, so the stimulus fills the FIFO to exactly the watermark and then one word beyond, for each scale setting. Blocking and resuming mid-drain are exercised in both buffer-test modes, so that a lost draining flag shows up as no request once the block clears.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;

  // Conditions the datapath evaluates for the control
  typedef struct packed {
    logic aboveMark;
    logic levelZero;
    logic noBuffer;
    logic markInvalid;
  } rxwmStatusT;

  // Strobes the control hands back to the datapath
  typedef struct packed {
    logic reqWindow;
    logic holdState;
  } rxwmStrobeT;

endpackage

// File: rtl/rxwm_datapath.sv
module rxwm_datapath
  import rxwm_pkg::*;
#(
  parameter int THR_W  = 7,
  parameter int LVL_W  = 8,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 128
) (
  input  logic [THR_W-1:0]  thrField,
  input  logic              mulX2En,
  input  logic              mulX4En,
  input  logic              modeSel,
  input  logic              holdSeen,
  input  logic [ADDR_W-1:0] curDescAddr,
  input  logic [ADDR_W-1:0] lastDescAddr,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic              dmaAck,
  input  rxwmStrobeT        strobe,
  output rxwmStatusT        status,
  output logic              dmaReq,
  output logic              fifoPop,
  output logic              cfgWarn
);

  localparam int MARK_W = THR_W + 3;
  localparam int CMP_W  = (MARK_W > LVL_W) ? MARK_W + 1 : LVL_W + 1;

  logic [MARK_W-1:0] scaledMark;
  logic [CMP_W-1:0]  markWide;
  logic [CMP_W-1:0]  levelWide;
  logic              bothScales;

  // Threshold scaling: shift by the selected power of two
  always_comb begin
    unique case ({mulX4En, mulX2En})
      2'b00:   scaledMark = MARK_W'(thrField);
      2'b01:   scaledMark = MARK_W'(thrField) << 1;
      2'b10:   scaledMark = MARK_W'(thrField) << 2;
      default: scaledMark = MARK_W'(thrField) << 3;
    endcase
  end

  assign markWide   = CMP_W'(scaledMark);
  assign levelWide  = CMP_W'(fifoLevel);
  assign bothScales = mulX2En & mulX4En;

  always_comb begin
    status.aboveMark   = levelWide > markWide;
    status.levelZero   = (fifoLevel == '0);
    status.markInvalid = markWide >= CMP_W'(DEPTH);
    status.noBuffer    = modeSel ? (curDescAddr == lastDescAddr) : holdSeen;
  end

  assign dmaReq  = strobe.reqWindow;
  assign fifoPop = strobe.reqWindow & dmaAck;
  assign cfgWarn = bothScales | status.markInvalid;

endmodule

// File: rtl/rxwm_control.sv
module rxwm_control
  import rxwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rxwmStatusT status,
  output rxwmStrobeT strobe
);

  typedef enum logic {IDLE = 1'b0, DRAIN = 1'b1} drainStateT;

  drainStateT stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      IDLE:    if (status.aboveMark && !status.markInvalid) stateD = DRAIN;
      default: if (status.levelZero) stateD = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.holdState = (stateQ == DRAIN) & status.noBuffer;
    strobe.reqWindow = (stateQ == DRAIN) & ~status.levelZero &
                       ~status.noBuffer & ~status.markInvalid;
  end

endmodule

// File: rtl/rx_watermark_dma.sv
module rx_watermark_dma
  import rxwm_pkg::*;
#(
  parameter int THR_W  = 7,
  parameter int LVL_W  = 8,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [THR_W-1:0]  thrField,
  input  logic              mulX2En,
  input  logic              mulX4En,
  input  logic              modeSel,
  input  logic              holdSeen,
  input  logic [ADDR_W-1:0] curDescAddr,
  input  logic [ADDR_W-1:0] lastDescAddr,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic              dmaAck,
  output logic              dmaReq,
  output logic              fifoPop,
  output logic              cfgWarn
);

  rxwmStatusT statusBus;
  rxwmStrobeT strobeBus;

  rxwm_datapath #(
    .THR_W(THR_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
  ) u_dp (
    .thrField(thrField), .mulX2En(mulX2En), .mulX4En(mulX4En),
    .modeSel(modeSel), .holdSeen(holdSeen),
    .curDescAddr(curDescAddr), .lastDescAddr(lastDescAddr),
    .fifoLevel(fifoLevel), .dmaAck(dmaAck),
    .strobe(strobeBus), .status(statusBus),
    .dmaReq(dmaReq), .fifoPop(fifoPop), .cfgWarn(cfgWarn)
  );

  rxwm_control u_ctl (
    .clk(clk), .rstN(rstN), .status(statusBus), .strobe(strobeBus)
  );

endmodule

// File: rtl/rx_watermark_dma_chk.sv
module rx_watermark_dma_chk #(
  parameter int THR_W  = 7,
  parameter int LVL_W  = 8,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic [THR_W-1:0]  thrField,
  input logic              mulX2En,
  input logic              mulX4En,
  input logic              modeSel,
  input logic              holdSeen,
  input logic [ADDR_W-1:0] curDescAddr,
  input logic [ADDR_W-1:0] lastDescAddr,
  input logic [LVL_W-1:0]  fifoLevel,
  input logic              dmaAck,
  input logic              dmaReq,
  input logic              fifoPop,
  input logic              cfgWarn
);

  int unsigned factor;
  int unsigned markVal;
  assign factor  = mulX4En ? (mulX2En ? 8 : 4) : (mulX2En ? 2 : 1);
  assign markVal = int'(thrField) * factor;

  // R10
  pop_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop == (dmaReq && dmaAck));

  // R4
  empty_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == '0) |-> !dmaReq);

  // R5
  hold_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel && holdSeen) |-> !dmaReq);

  // R6
  addr_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel && (curDescAddr == lastDescAddr)) |-> !dmaReq);

  // R9
  bad_mark_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (markVal >= DEPTH) |-> !dmaReq);

  // R8
  warn_scale_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mulX2En && mulX4En) |-> cfgWarn);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> !dmaReq);

endmodule

bind rx_watermark_dma rx_watermark_dma_chk #(
  .THR_W(THR_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rstN(rstN), .thrField(thrField), .mulX2En(mulX2En),
  .mulX4En(mulX4En), .modeSel(modeSel), .holdSeen(holdSeen),
  .curDescAddr(curDescAddr), .lastDescAddr(lastDescAddr),
  .fifoLevel(fifoLevel), .dmaAck(dmaAck), .dmaReq(dmaReq),
  .fifoPop(fifoPop), .cfgWarn(cfgWarn)
);

// File: tb/tb_rx_watermark_dma.sv
`timescale 1ns/1ps
module tb_rx_watermark_dma;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  thrField = 7'd5;
  logic        mulX2En = 1'b0;
  logic        mulX4En = 1'b0;
  logic        modeSel = 1'b0;
  logic        holdSeen = 1'b0;
  logic [31:0] curDescAddr = 32'h100;
  logic [31:0] lastDescAddr = 32'h200;
  logic [7:0]  fifoLevel;
  logic        dmaAck = 1'b0;
  logic        dmaReq, fifoPop, cfgWarn;

  int    lvl = 0;
  int    pushN = 0;
  bit    mDrain = 1'b0;
  int    nChecks = 0;
  int    nFails = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string curReq = "R11";

  always #2 clk = ~clk;  // 250 MHz

  assign fifoLevel = lvl[7:0];

  rx_watermark_dma dut (
    .clk(clk), .rstN(rstN), .thrField(thrField), .mulX2En(mulX2En),
    .mulX4En(mulX4En), .modeSel(modeSel), .holdSeen(holdSeen),
    .curDescAddr(curDescAddr), .lastDescAddr(lastDescAddr),
    .fifoLevel(fifoLevel), .dmaAck(dmaAck), .dmaReq(dmaReq),
    .fifoPop(fifoPop), .cfgWarn(cfgWarn)
  );

  function automatic int markOf();
    int f;
    f = mulX4En ? (mulX2En ? 8 : 4) : (mulX2En ? 2 : 1);
    return int'(thrField) * f;
  endfunction

  function automatic bit blockedNow();
    return modeSel ? (curDescAddr == lastDescAddr) : holdSeen;
  endfunction

  function automatic bit expReq();
    return mDrain && (lvl != 0) && !blockedNow() && (markOf() < 128);
  endfunction

  // Behavioural model: FIFO occupancy and drain flag
  always @(posedge clk) begin
    int nxt;
    if (!rstN)       mDrain <= 1'b0;
    else if (mDrain) mDrain <= (lvl != 0);
    else             mDrain <= (lvl > markOf()) && (markOf() < 128);
    nxt = lvl + pushN - ((expReq() && dmaAck) ? 1 : 0);
    if (nxt > 128) nxt = 128;
    lvl <= nxt;
  end

  task automatic checkBit(input string req, input logic act, input bit exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      checkBit(curReq, dmaReq, expReq());
      checkBit("R10", fifoPop, expReq() && dmaAck);
      checkBit("R8", cfgWarn, (mulX2En && mulX4En) || (markOf() >= 128));
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic addWords(input int k);
    pushN = k;
    waitCyc(1);
    pushN = 0;
  endtask

  initial begin
    #1;
    // R11: FIFO above the watermark while held in reset
    curReq = "R11";
    addWords(10);
    waitCyc(3);
    rstN = 1'b1;
    // R2: level 10 above watermark 5, no acknowledge yet
    curReq = "R2";
    waitCyc(3);
    // R3: drain below the watermark down to empty
    curReq = "R3";
    dmaAck = 1'b1;
    waitCyc(12);
    // R4: idle at zero
    curReq = "R4";
    waitCyc(3);
    // R2: level equal to the watermark does not start
    curReq = "R2";
    dmaAck = 1'b0;
    addWords(5);
    waitCyc(3);
    addWords(1);
    waitCyc(2);
    // R10: toggling acknowledge
    curReq = "R10";
    for (int i = 0; i < 8; i++) begin
      dmaAck = i[0];
      waitCyc(1);
    end
    dmaAck = 1'b1;
    waitCyc(10);
    // R1: x2, x4 and x8 scales
    curReq = "R1";
    dmaAck = 1'b0;
    thrField = 7'd3;
    mulX2En = 1'b1;
    addWords(6);
    waitCyc(2);
    addWords(1);
    waitCyc(2);
    dmaAck = 1'b1;
    waitCyc(10);
    dmaAck = 1'b0;
    mulX2En = 1'b0;
    mulX4En = 1'b1;
    addWords(12);
    waitCyc(2);
    addWords(1);
    waitCyc(2);
    dmaAck = 1'b1;
    waitCyc(16);
    curReq = "R8";
    dmaAck = 1'b0;
    mulX2En = 1'b1;
    addWords(24);
    waitCyc(2);
    addWords(1);
    waitCyc(2);
    dmaAck = 1'b1;
    waitCyc(30);
    // R9: watermark of 128 suppresses requests
    curReq = "R9";
    mulX2En = 1'b0;
    thrField = 7'd32;
    addWords(100);
    addWords(28);
    waitCyc(4);
    thrField = 7'd40;
    waitCyc(2);
    curReq = "R4";
    thrField = 7'd0;
    mulX4En = 1'b0;
    waitCyc(135);
    // R5: hold flag blocks in mode 0, R7: resume
    curReq = "R5";
    thrField = 7'd2;
    modeSel = 1'b0;
    curDescAddr = 32'h300;
    lastDescAddr = 32'h300;
    addWords(20);
    waitCyc(3);
    holdSeen = 1'b1;
    waitCyc(4);
    curReq = "R7";
    holdSeen = 1'b0;
    waitCyc(30);
    // R6: address compare blocks in mode 1, hold flag ignored
    curReq = "R6";
    modeSel = 1'b1;
    holdSeen = 1'b1;
    curDescAddr = 32'h100;
    lastDescAddr = 32'h200;
    addWords(20);
    waitCyc(3);
    lastDescAddr = 32'h100;
    waitCyc(4);
    curReq = "R7";
    lastDescAddr = 32'h400;
    waitCyc(30);
    // R11: reset mid-drain
    curReq = "R11";
    addWords(10);
    waitCyc(2);
    rstN = 1'b0;
    waitCyc(2);
    rstN = 1'b1;
    waitCyc(20);
    finishRun();
  end

endmodule